// File: doc/BRIEF.md
# Tag Start-Up Sequencer

This block brings a passive transponder tag from power-on reset to its regular read mode. Once the power-on reset input releases, it counts field clocks and holds the load-damping output on. In a window of fixed length it reads the configuration word from nonvolatile block 0 over a request/valid port. At the end of that window it samples one delay-enable bit of the word. If the bit is clear, it raises `ready` at once. If the bit is set, it first keeps damping on for a long extra hold period.

Field clocks arrive as a one-cycle `field_tick` strobe on the system clock, so the carrier divider can sit elsewhere. `ready` lets the regular-read modulator start. `damp_on` drives the load-damping switch. The two outputs are registered and are never high together.

Top module: `tag_startup_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, `damp_on`, `ready` and `mem_req` are all low after that edge.
- R2: On the first clock edge with `rst_n` high after reset, `damp_on` and `mem_req` both go high, and `mem_addr` reads 0 while `mem_req` is high.
- R3: `mem_req` stays high until an edge at which `mem_valid` is high. The word on `mem_rdata` is captured at that edge and `mem_req` drops. A `mem_valid` pulse while `mem_req` is low has no effect on the captured word or on the timing of `ready`.
- R4: Field ticks are counted only while in the configuration window or the extra hold. If the captured word has bit `DLY_BIT` (default 4) clear, `ready` rises and `damp_on` falls at the edge that samples the 192nd tick, so 192 damped ticks precede `ready`.
- R5: If the captured word has bit `DLY_BIT` set, damping continues for a further 8190 ticks. `ready` rises at the edge that samples the 8190th tick of that hold, so 8382 damped ticks precede `ready` in total.
- R6: If no word has arrived when the 192nd tick is sampled, damping stays on and ticks are ignored until `mem_valid` arrives. At that edge the decision of R4/R5 is taken (ready one edge later, or the hold starts). A `mem_valid` in the same cycle as the 192nd tick counts as arrived in time.
- R7: `damp_on` and `ready` are never high together. Once high, `ready` stays high until reset. `damp_on` stays high on every cycle from the first edge after reset release until `ready` rises.
- R8: Pulling `rst_n` low at any point of the sequence, including mid-hold, returns all outputs to the R1 state at the next edge. The next release restarts the sequence from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, sampled synchronously |
| field_tick | input | 1 | One-cycle strobe per field clock |
| mem_req | output | 1 | Configuration read request, held until valid |
| mem_addr | output | ADDR_W | Block address of the read, always block 0 |
| mem_valid | input | 1 | Read data valid strobe |
| mem_rdata | input | DATA_W | Configuration word returned by memory |
| damp_on | output | 1 | Load-damping control, high through start-up |
| ready | output | 1 | Start-up complete, regular read may begin |

## Verification
The end of the configuration window and the return of the configuration word can fall on the same clock edge. In that case the decision must use the word arriving on that very edge and must not fall into the waiting state. The bench provokes this by timing the memory response so that `mem_valid` is sampled together with the 192nd tick, with the delay bit set. The run is judged by the measured 8382 damped ticks before `ready` and by a cycle-by-cycle reference model. Other runs cover the window ending long before the data returns, a stray valid after capture, and reset in the middle of the hold.

// File: rtl/tss_pkg.sv
// Package: shared types for the tag start-up sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package tss_pkg;

    // Phases of the start-up sequence
    typedef enum logic [2:0] {
        ST_OFF  = 3'd0,   // held in or just out of reset
        ST_CFG  = 3'd1,   // configuration window, counting ticks
        ST_WAIT = 3'd2,   // window over, word not yet returned
        ST_HOLD = 3'd3,   // extra damping hold
        ST_RDY  = 3'd4    // start-up complete
    } tss_state_e;

endpackage

// File: rtl/tss_tick_counter.sv
// Module: tss_tick_counter
// Counts field-clock strobes while enabled and flags the strobe that
// reaches a run-time limit. The owner clears it on every phase change.
// Assumes: limit is at least 1 and fits in CNT_W bits.
module tss_tick_counter #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    // Count strobes in the active phase; clear takes priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (en && tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Terminal strobe: this tick is the limit-th one of the phase
    always_comb begin
        done = en && tick && (cnt_q == (limit - 1'b1));
    end

endmodule

// File: rtl/tss_cfg_fetch.sv
// Module: tss_cfg_fetch
// Issues the single read of the configuration block, holds the request
// until the memory answers, captures the word and presents the
// delay-enable bit. The bit is taken straight from the read bus in the
// cycle the word arrives, so the caller can decide in that cycle.
// Assumes: memory answers with a one-cycle valid strobe; a valid strobe
// without an outstanding request is ignored.
module tss_cfg_fetch #(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 4,
    parameter int CFG_ADDR = 0,
    parameter int DLY_BIT  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mem_valid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              word_have,
    output logic              word_arrive,
    output logic              dly_bit
);

    logic              req_q;
    logic              have_q;
    logic [DATA_W-1:0] word_q;
    logic              unused_word;

    // Handshake state and word capture register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            have_q <= 1'b0;
            word_q <= '0;
        end else if (start) begin
            req_q  <= 1'b1;
            have_q <= 1'b0;
        end else if (word_arrive) begin
            req_q  <= 1'b0;
            have_q <= 1'b1;
            word_q <= mem_rdata;
        end
    end

    // Arrival only counts against an outstanding request
    always_comb begin
        word_arrive = req_q && mem_valid;
    end

    // Delay bit: stored copy once held, read bus in the arrival cycle
    always_comb begin
        dly_bit = have_q ? word_q[DLY_BIT] : mem_rdata[DLY_BIT];
    end

    assign mem_req     = req_q;
    assign mem_addr    = ADDR_W'(CFG_ADDR);
    assign word_have   = have_q;
    assign unused_word = ^word_q;

endmodule

// File: rtl/tss_ctrl.sv
// Module: tss_ctrl
// Phase controller of the start-up sequence. Chooses the next phase from
// the tick counter, the fetch status and the delay bit. Drives the
// registered damping and ready outputs from the next phase, so both
// change on the same edge as the phase itself.
// Assumes: cnt_done is only raised in the CFG and HOLD phases.
module tss_ctrl
    import tss_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cnt_done,
    input  logic word_have,
    input  logic word_arrive,
    input  logic dly_bit,
    output logic fetch_start,
    output logic cnt_clr,
    output logic cnt_en,
    output logic cnt_sel_hold,
    output logic damp_on,
    output logic ready
);

    tss_state_e state_q;
    tss_state_e state_d;
    logic       damp_q;
    logic       ready_q;
    tss_state_e after_cfg;

    // Phase that follows once the configuration word is known
    always_comb begin
        after_cfg = dly_bit ? ST_HOLD : ST_RDY;
    end

    // Next-phase selection
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_OFF:  state_d = ST_CFG;
            ST_CFG: begin
                if (cnt_done) begin
                    state_d = (word_have || word_arrive) ? after_cfg : ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (word_arrive) begin
                    state_d = after_cfg;
                end
            end
            ST_HOLD: begin
                if (cnt_done) begin
                    state_d = ST_RDY;
                end
            end
            ST_RDY:  state_d = ST_RDY;
            default: state_d = ST_OFF;
        endcase
    end

    // Phase register and registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            damp_q  <= 1'b0;
            ready_q <= 1'b0;
        end else begin
            state_q <= state_d;
            damp_q  <= (state_d == ST_CFG) || (state_d == ST_WAIT) ||
                       (state_d == ST_HOLD);
            ready_q <= (state_d == ST_RDY);
        end
    end

    // Counter and fetch control derived from the current phase
    always_comb begin
        fetch_start  = (state_q == ST_OFF);
        cnt_en       = (state_q == ST_CFG) || (state_q == ST_HOLD);
        cnt_sel_hold = (state_q == ST_HOLD);
        cnt_clr      = (state_d != state_q);
    end

    assign damp_on = damp_q;
    assign ready   = ready_q;

endmodule

// File: rtl/tag_startup_seq.sv
// Module: tag_startup_seq (top)
// Power-up sequencer of a passive tag: after reset release it damps the
// coil, fetches the configuration word of block 0, counts the
// configuration window and an optional long hold, then raises ready.
// Assumes: field_tick is a single-cycle strobe synchronous to clk; the
// reset input already reflects an adequate supply level.
module tag_startup_seq #(
    parameter int CFG_CLKS  = 192,
    parameter int HOLD_CLKS = 8190,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 4,
    parameter int CFG_ADDR  = 0,
    parameter int DLY_BIT   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              field_tick,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              damp_on,
    output logic              ready
);

    localparam int MAX_CLKS = (CFG_CLKS > HOLD_CLKS) ? CFG_CLKS : HOLD_CLKS;
    localparam int CNT_W    = $clog2(MAX_CLKS + 1);
    localparam logic [CNT_W-1:0] CFG_LIM  = CNT_W'(CFG_CLKS);
    localparam logic [CNT_W-1:0] HOLD_LIM = CNT_W'(HOLD_CLKS);

    logic             fetch_start;
    logic             word_have;
    logic             word_arrive;
    logic             dly_bit;
    logic             cnt_clr;
    logic             cnt_en;
    logic             cnt_sel_hold;
    logic             cnt_done;
    logic [CNT_W-1:0] cnt_limit;

    // Window length for the phase being counted
    always_comb begin
        cnt_limit = cnt_sel_hold ? HOLD_LIM : CFG_LIM;
    end

    tss_cfg_fetch #(
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .CFG_ADDR(CFG_ADDR),
        .DLY_BIT (DLY_BIT)
    ) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (fetch_start),
        .mem_valid  (mem_valid),
        .mem_rdata  (mem_rdata),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .word_have  (word_have),
        .word_arrive(word_arrive),
        .dly_bit    (dly_bit)
    );

    tss_tick_counter #(
        .CNT_W(CNT_W)
    ) u_count (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cnt_clr),
        .en   (cnt_en),
        .tick (field_tick),
        .limit(cnt_limit),
        .done (cnt_done)
    );

    tss_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt_done    (cnt_done),
        .word_have   (word_have),
        .word_arrive (word_arrive),
        .dly_bit     (dly_bit),
        .fetch_start (fetch_start),
        .cnt_clr     (cnt_clr),
        .cnt_en      (cnt_en),
        .cnt_sel_hold(cnt_sel_hold),
        .damp_on     (damp_on),
        .ready       (ready)
    );

endmodule

// File: rtl/tss_checker.sv
// Module: tss_checker
// Protocol and sequencing properties of the start-up sequencer, observed
// at its ports. Bound into every instance of tag_startup_seq.
// Assumes: rst_n is low at the first clock edge.
module tss_checker #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              damp_on,
    input logic              ready,
    input logic              mem_req,
    input logic              mem_valid,
    input logic [ADDR_W-1:0] mem_addr
);

    // R1 / R8: reset returns every output low at the next edge
    a_r8_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!damp_on && !ready && !mem_req));

    // R2: the read request starts together with damping
    a_r2_req_with_damp: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(damp_on) |-> mem_req);

    // R2: the request always addresses block 0
    a_r2_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr == '0));

    // R3: request held until answered
    a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> mem_req);

    // R3: request withdrawn once answered
    a_r3_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_valid) |=> !mem_req);

    // R7: damping and ready never overlap
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(damp_on && ready));

    // R7: ready is sticky until reset
    a_r7_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R7: damping ends only by handing over to ready
    a_r7_damp_to_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(damp_on) && $past(rst_n)) |-> ready);

endmodule

bind tag_startup_seq tss_checker #(.ADDR_W(ADDR_W)) u_tss_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .damp_on  (damp_on),
    .ready    (ready),
    .mem_req  (mem_req),
    .mem_valid(mem_valid),
    .mem_addr (mem_addr)
);

// File: tb/tag_startup_seq_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared every cycle, plus directed
// measurements of the start-up length and damping coverage.
module tag_startup_seq_tb_top;

    localparam int CFG_N  = 192;
    localparam int HOLD_N = 8190;
    localparam int DBIT   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        field_tick = 1'b0;
    logic        mem_req;
    logic [3:0]  mem_addr;
    logic        mem_valid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        damp_on;
    logic        ready;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    tag_startup_seq dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .field_tick(field_tick),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_valid (mem_valid),
        .mem_rdata (mem_rdata),
        .damp_on   (damp_on),
        .ready     (ready)
    );

    // ---------------- reference model ----------------
    int m_ph   = 0;   // 0 off, 1 window, 2 waiting, 3 hold, 4 ready
    int m_cnt  = 0;
    bit m_req  = 0;
    bit m_have = 0;
    bit m_bit  = 0;
    bit started = 0;

    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_req = 0; m_have = 0;
        end else begin
            case (m_ph)
                0: begin m_ph = 1; m_cnt = 0; m_req = 1; m_have = 0; end
                1: begin
                    if (m_req && mem_valid) begin
                        m_have = 1; m_bit = mem_rdata[DBIT]; m_req = 0;
                    end
                    if (field_tick) begin
                        m_cnt++;
                        if (m_cnt == CFG_N) begin
                            m_cnt = 0;
                            m_ph = !m_have ? 2 : (m_bit ? 3 : 4);
                        end
                    end
                end
                2: begin
                    if (m_req && mem_valid) begin
                        m_have = 1; m_bit = mem_rdata[DBIT]; m_req = 0;
                        m_ph = m_bit ? 3 : 4;
                    end
                end
                3: begin
                    if (field_tick) begin
                        m_cnt++;
                        if (m_cnt == HOLD_N) m_ph = 4;
                    end
                end
                default: ;
            endcase
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // stimulus state
    int  tick_mode  = 0;     // 0 every cycle, 1 every other, 2 two of three
    int  tick_phase = 0;
    int  resp_wait  = -1;
    logic [31:0] resp_word = '0;
    bit  spur_now   = 0;
    logic [31:0] spur_word = '0;
    int  cyc        = 0;
    int  meas       = 0;
    int  gap        = 0;
    int  valid_cyc  = -1;
    int  ready_cyc  = -1;
    bit  run_on     = 0;

    // One cycle: compare at the falling edge, then drive the next inputs
    task automatic step();
        bit nt;
        @(negedge clk);
        cyc++;
        if (started) begin
            chk(damp_on === (m_ph inside {1, 2, 3}), "R4/R5/R6 damp_on", damp_on, m_ph inside {1, 2, 3});
            chk(ready === (m_ph == 4), "R4/R7 ready", ready, m_ph == 4);
            chk(mem_req === m_req, "R3 mem_req", mem_req, m_req);
        end
        if (run_on && rst_n && !ready && !damp_on && cyc > 1) gap++;
        if (ready && ready_cyc < 0) ready_cyc = cyc;
        // memory responder
        mem_valid = 1'b0;
        if (spur_now) begin
            mem_valid = 1'b1; mem_rdata = spur_word; spur_now = 0;
        end else if (mem_req && resp_wait >= 0) begin
            if (resp_wait == 0) begin
                mem_valid = 1'b1; mem_rdata = resp_word; resp_wait = -1; valid_cyc = cyc;
            end else begin
                resp_wait--;
            end
        end
        // field strobe pattern
        tick_phase++;
        case (tick_mode)
            0: nt = 1'b1;
            1: nt = tick_phase[0];
            default: nt = (tick_phase % 3) != 0;
        endcase
        field_tick = nt;
        if (nt && damp_on && rst_n) meas++;
    endtask

    // Full start-up: reset, release, run to ready or an abort point
    task automatic run_seq(input logic [31:0] word, input int lat, input int mode,
                           input int spur_at, input int abort_at);
        rst_n = 1'b0;
        repeat (3) step();
        tick_mode = mode; resp_word = word; resp_wait = lat;
        meas = 0; gap = 0; valid_cyc = -1; ready_cyc = -1; cyc = 0;
        rst_n = 1'b1; run_on = 1;
        for (int i = 0; i < 20000; i++) begin
            step();
            if (i == spur_at) begin
                spur_now = 1; spur_word = ~word;
            end
            if (i == abort_at) break;
            if (ready) break;
        end
        run_on = 0;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(5.0 * 160000);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    // ---------------- directed sequence ----------------
    initial begin
        // R1: reset state
        repeat (4) step();
        chk(!damp_on && !ready && !mem_req, "R1 outputs low in reset",
            {damp_on, ready, mem_req}, 0);

        // R2: first edge after release
        resp_wait = -1; tick_mode = 0;
        rst_n = 1'b1;
        step();
        step();
        chk(damp_on === 1'b1, "R2 damping starts", damp_on, 1);
        chk(mem_req === 1'b1, "R2 request starts", mem_req, 1);
        chk(mem_addr === 4'd0, "R2 block 0 addressed", mem_addr, 0);

        // R4: delay bit clear, early data, tick every cycle
        run_seq(32'hA5A5_A5E5, 5, 0, -1, -1);
        chk(ready === 1'b1, "R4 ready reached", ready, 1);
        chk(meas == CFG_N, "R4 damped ticks before ready", meas, CFG_N);
        chk(gap == 0, "R7 damping unbroken", gap, 0);
        step();
        chk(ready === 1'b1 && damp_on === 1'b0, "R7 ready holds", ready, 1);

        // R5: delay bit set, sparse ticks
        run_seq(32'h0000_0010, 20, 1, -1, -1);
        chk(meas == CFG_N + HOLD_N, "R5 damped ticks with hold", meas, CFG_N + HOLD_N);
        chk(gap == 0, "R7 damping unbroken through hold", gap, 0);

        // R6: data returns long after the window
        run_seq(32'h0000_0000, 400, 0, -1, -1);
        chk(ready === 1'b1, "R6 ready after late data", ready, 1);
        chk(ready_cyc - valid_cyc == 1, "R6 ready one edge after valid",
            ready_cyc - valid_cyc, 1);
        chk(gap == 0, "R6 damping held while waiting", gap, 0);

        // R6: valid sampled with the 192nd tick, delay bit set
        run_seq(32'hFFFF_FFFF, CFG_N - 1, 0, -1, -1);
        chk(meas == CFG_N + HOLD_N, "R6 same-cycle arrival honoured", meas, CFG_N + HOLD_N);

        // R3: stray valid after capture is ignored
        run_seq(32'h0000_0000, 2, 2, 50, -1);
        chk(meas == CFG_N, "R3 stray valid ignored", meas, CFG_N);
        chk(ready === 1'b1, "R3 ready after stray valid", ready, 1);

        // R8: reset in the middle of the hold, then clean restart
        run_seq(32'h0000_0010, 3, 0, -1, 1000);
        chk(damp_on === 1'b1 && ready === 1'b0, "R8 mid-hold state", damp_on, 1);
        rst_n = 1'b0;
        step();
        step();
        chk(!damp_on && !ready && !mem_req, "R8 reset mid-hold clears",
            {damp_on, ready, mem_req}, 0);
        run_seq(32'h0000_0000, 1, 0, -1, -1);
        chk(meas == CFG_N, "R8 restart from beginning", meas, CFG_N);

        repeat (3) step();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule